// File: doc/BRIEF.md
# Period and Pulse-Width Gating Sequencer

This block produces a stream of time-base ticks whose length encodes either the full period or the high time of a slow digital input. A downstream event counter counts the ticks. The count multiplied by the chosen tick period is the measured interval.

A restart pulse arms a ten-state one-hot sequencer. After a two-flop synchronizer, each rising edge of the input moves the sequencer one state forward. When it reaches its last state it stays there until the next restart. While the window state (the second state) is active, the gate passes ticks from one of four time bases: 1, 10, 100 or 1000 µs. These come from a 1 µs master tick followed by three divide-by-ten stages. In pulse-width mode the gate also needs the input level, aligned to the sequencer, to be high. Mode and time-base select are captured at restart.

Top module: `periodGateSeq`

## Requirements
- R1: After reset the sequencer is parked in its last state. `busyO` is 0 and `gatedTickO` stays 0 whatever `sigI` does.
- R2: A restart pulse puts the sequencer in its first state on the next clock edge and raises `busyO` there. Restart wins over a simultaneous input edge.
- R3: Each rising edge of the synchronized input advances the one-hot sequencer by exactly one state. Each state therefore lasts one input period.
- R4: The ninth rising edge after restart parks the sequencer and drops `busyO`. Later edges have no effect until the next restart.
- R5: In period mode (`modeI`=0) ticks pass only while the window state is active. For an input period of exactly N tick periods, exactly N ticks are emitted per measurement.
- R6: In pulse-width mode (`modeI`=1) ticks pass only while the window state is active and the aligned input is high. For a high time of exactly M tick periods, exactly M ticks are emitted.
- R7: The time-base select picks the tick period: `tbSelI`=0 gives 1 µs, 1 gives 10 µs, 2 gives 100 µs and 3 gives 1000 µs. One µs is `TICK_DIV` clock cycles.
- R8: `modeI` and `tbSelI` are sampled only on the restart cycle. Changing them during a measurement has no effect on it.
- R9: If the input stays idle after restart, the block waits indefinitely with `busyO` high and emits no ticks.
- R10: Each gated tick is a single-cycle pulse. With the 1 µs base, no two gated ticks fall in consecutive cycles when `TICK_DIV` ≥ 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restartI | input | 1 | Single-cycle pulse that arms a new measurement |
| modeI | input | 1 | 0 = period, 1 = pulse width (high time) |
| tbSelI | input | 2 | Time-base select, 0..3 = 1, 10, 100, 1000 µs |
| sigI | input | 1 | Asynchronous input being measured |
| gatedTickO | output | 1 | Gated tick stream for an external counter |
| busyO | output | 1 | High from restart until the sequencer parks |

## Verification
A one-hot state that skips, stalls or doubles shows up at the ports as a wrong tick total. The window then covers zero or two input periods, so the error is visible at the end of the measurement, usually within one or two input periods. A park state that fails to hold shows up as `busyO` rising again, or as ticks after the ninth edge, on the first extra input edge. A latched mode or select that follows the live inputs changes the tick total of the very measurement in which they are moved. A misaligned level term in pulse-width mode gives an off-by-one count, which exact-multiple high times expose.

// File: rtl/pgsPkg.sv
package pgsPkg;
  localparam int SEL_W = 2;
  localparam int NUM_BASES = 1 << SEL_W;

  typedef enum logic {
    MODE_PERIOD = 1'b0,
    MODE_MARK   = 1'b1
  } pgsMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             windowOpen;
    pgsMode_e         mode;
    logic [SEL_W-1:0] tbSel;
  } pgsCtrl_t;
endpackage

// File: rtl/pgsDatapath.sv
module pgsDatapath
  import pgsPkg::*;
#(
  parameter int TICK_DIV    = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sigI,
  input  pgsCtrl_t ctrl,
  output logic     inRise,
  output logic     sigLvl,
  output logic     gatedTickO
);
  localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int NUM_DEC = NUM_BASES - 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  // input synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], sigI};
  end

  logic syncSig;
  assign syncSig = syncChain[SYNC_STAGES-1];

  // level delayed by one so it lines up with the sequencer state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sigLvl <= 1'b0;
    else       sigLvl <= syncSig;
  end

  assign inRise = syncSig & ~sigLvl;

  // master tick prescaler
  logic [PRE_W-1:0] preCnt;
  logic [NUM_BASES-1:0] tickVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else                       preCnt <= preCnt + 1'b1;
  end

  assign tickVec[0] = (preCnt == PRE_LAST);

  // cascaded decade stages
  for (genvar g = 0; g < NUM_DEC; g++) begin : gDecade
    logic [3:0] decCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              decCnt <= '0;
      else if (tickVec[g]) begin
        if (decCnt == 4'd9)   decCnt <= '0;
        else                  decCnt <= decCnt + 4'd1;
      end
    end
    assign tickVec[g+1] = tickVec[g] & (decCnt == 4'd9);
  end

  // gate: window AND selected tick AND (level or forced high)
  logic selTick;
  logic thirdTerm;
  assign selTick   = tickVec[ctrl.tbSel];
  assign thirdTerm = (ctrl.mode == MODE_MARK) ? sigLvl : 1'b1;
  assign gatedTickO = ctrl.windowOpen & selTick & thirdTerm;
endmodule

// File: rtl/pgsControl.sv
module pgsControl
  import pgsPkg::*;
#(
  parameter int NUM_STATES = 10,
  parameter int WIN_STATE  = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  restartI,
  input  logic                  modeI,
  input  logic [SEL_W-1:0]      tbSelI,
  input  logic                  inRise,
  output pgsCtrl_t              ctrl,
  output logic [NUM_STATES-1:0] stateO,
  output logic                  busyO
);
  localparam int LAST = NUM_STATES - 1;
  localparam logic [NUM_STATES-1:0] PARKED = NUM_STATES'(1) << LAST;
  localparam logic [NUM_STATES-1:0] FIRST  = NUM_STATES'(1);

  logic [NUM_STATES-1:0] stateQ;
  logic                  parked;
  pgsMode_e              modeQ;
  logic [SEL_W-1:0]      selQ;

  assign parked = stateQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    stateQ <= PARKED;
    else if (restartI)            stateQ <= FIRST;
    else if (inRise && !parked)   stateQ <= stateQ << 1;
  end

  // busy tracked separately: cleared on the edge that enters the park state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              busyO <= 1'b0;
    else if (restartI)                      busyO <= 1'b1;
    else if (inRise && stateQ[LAST-1])      busyO <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_PERIOD;
      selQ  <= '0;
    end else if (restartI) begin
      modeQ <= pgsMode_e'(modeI);
      selQ  <= tbSelI;
    end
  end

  always_comb begin
    ctrl.windowOpen = stateQ[WIN_STATE];
    ctrl.mode       = modeQ;
    ctrl.tbSel      = selQ;
  end

  assign stateO = stateQ;
endmodule

// File: rtl/periodGateSeq.sv
module periodGateSeq
  import pgsPkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int NUM_STATES = 10,
  parameter int WIN_STATE  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       restartI,
  input  logic       modeI,
  input  logic [1:0] tbSelI,
  input  logic       sigI,
  output logic       gatedTickO,
  output logic       busyO
);
  pgsCtrl_t              ctrl;
  logic [NUM_STATES-1:0] stateVec;
  logic                  inRise;
  logic                  sigLvl;

  pgsControl #(.NUM_STATES(NUM_STATES), .WIN_STATE(WIN_STATE)) uCtrl (
    .clk(clk), .rstN(rstN), .restartI(restartI), .modeI(modeI),
    .tbSelI(tbSelI), .inRise(inRise), .ctrl(ctrl), .stateO(stateVec),
    .busyO(busyO)
  );

  pgsDatapath #(.TICK_DIV(TICK_DIV), .SYNC_STAGES(2)) uDp (
    .clk(clk), .rstN(rstN), .sigI(sigI), .ctrl(ctrl), .inRise(inRise),
    .sigLvl(sigLvl), .gatedTickO(gatedTickO)
  );
endmodule

// File: rtl/pgsCheck.sv
module pgsCheck #(
  parameter int N   = 10,
  parameter int WIN = 1
) (
  input logic         clk,
  input logic         rstN,
  input logic         restartI,
  input logic         inRise,
  input logic         sigLvl,
  input logic         markMode,
  input logic [N-1:0] state,
  input logic         busyO,
  input logic         gatedTickO
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(state));

  p_restart_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    restartI |=> (state == N'(1)) && busyO);

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!restartI && inRise && !state[N-1]) |=> (state == ($past(state) << 1)));

  p_park_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!restartI && state[N-1]) |=> $stable(state));

  p_busy_park_r4: assert property (@(posedge clk) disable iff (!rstN)
    busyO != state[N-1]);

  p_gate_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    gatedTickO |-> state[WIN] && busyO);

  p_mark_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gatedTickO && markMode) |-> sigLvl);
endmodule

bind periodGateSeq pgsCheck #(.N(NUM_STATES), .WIN(WIN_STATE)) uChk (
  .clk(clk), .rstN(rstN), .restartI(restartI), .inRise(inRise),
  .sigLvl(sigLvl), .markMode(ctrl.mode), .state(stateVec),
  .busyO(busyO), .gatedTickO(gatedTickO)
);

// File: tb/tb_periodGateSeq.sv
`timescale 1ns/1ps
module tb_periodGateSeq;
  localparam int TDIV = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic restartI = 1'b0;
  logic modeI = 1'b0;
  logic [1:0] tbSelI = 2'd0;
  logic sigI = 1'b0;
  logic gatedTickO, busyO;

  int errors = 0;
  int checks = 0;
  int tickCnt = 0;
  int backToBack = 0;
  logic prevGated = 1'b0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  periodGateSeq #(.TICK_DIV(TDIV)) dut (
    .clk(clk), .rstN(rstN), .restartI(restartI), .modeI(modeI),
    .tbSelI(tbSelI), .sigI(sigI), .gatedTickO(gatedTickO), .busyO(busyO)
  );

  always @(negedge clk) begin
    if (gatedTickO) tickCnt++;
    if (gatedTickO && prevGated) backToBack++;
    prevGated = gatedTickO;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic m, input logic [1:0] s);
    @(negedge clk);
    modeI = m; tbSelI = s; restartI = 1'b1;
    @(negedge clk);
    restartI = 1'b0;
    tickCnt = 0;
  endtask

  task automatic train(input int period, input int high, input int n);
    for (int i = 0; i < n; i++) begin
      sigI = 1'b1;
      repeat (high) @(negedge clk);
      sigI = 1'b0;
      repeat (period - high) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 busy after reset", busyO, 0);
    tickCnt = 0;
    train(20, 10, 4);
    chk("R1 no ticks while parked", tickCnt, 0);
    chk("R1 busy stays low", busyO, 0);
  endtask

  task automatic testPeriodBases();
    int base;
    base = TDIV;
    for (int s = 0; s < 4; s++) begin
      restart(1'b0, 2'(s));
      chk("R2 busy after restart", busyO, 1);
      train(base * ((s == 3) ? 2 : 10), base, 10);
      chk($sformatf("R5 R7 period count sel%0d", s), tickCnt, (s == 3) ? 2 : 10);
      chk("R4 parked after train", busyO, 0);
      base = base * 10;
    end
  endtask

  task automatic testWidth();
    restart(1'b1, 2'd0);
    train(40, 14, 10);
    chk("R6 width count sel0", tickCnt, 7);
    restart(1'b1, 2'd1);
    train(200, 60, 10);
    chk("R6 R7 width count sel1", tickCnt, 3);
  endtask

  task automatic testPark();
    restart(1'b0, 2'd0);
    train(20, 5, 8);
    chk("R3 busy after eight edges", busyO, 1);
    train(20, 5, 1);
    chk("R4 busy after ninth edge", busyO, 0);
    tickCnt = 0;
    train(20, 5, 5);
    chk("R4 edges ignored when parked", tickCnt, 0);
    chk("R4 busy stays low", busyO, 0);
  endtask

  task automatic testLatch();
    restart(1'b0, 2'd0);
    modeI = 1'b1; tbSelI = 2'd3;
    train(20, 4, 10);
    chk("R8 mode/select held from restart", tickCnt, 10);
  endtask

  task automatic testIdle();
    restart(1'b0, 2'd0);
    repeat (600) @(negedge clk);
    chk("R9 no ticks while idle", tickCnt, 0);
    chk("R9 busy while idle", busyO, 1);
  endtask

  task automatic testRearm();
    restart(1'b0, 2'd0);
    sigI = 1'b1;
    repeat (8) @(negedge clk);
    sigI = 1'b0;
    repeat (6) @(negedge clk);
    restart(1'b0, 2'd0);
    repeat (200) @(negedge clk);
    chk("R2 restart closes open window", tickCnt, 0);
    train(30, 10, 10);
    chk("R2 R3 count after re-arm", tickCnt, 15);
  endtask

  task automatic testPulseShape();
    backToBack = 0;
    restart(1'b0, 2'd0);
    train(60, 30, 10);
    chk("R10 ticks are single-cycle", backToBack, 0);
    chk("R10 tick count", tickCnt, 30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPeriodBases();
    testWidth();
    testPark();
    testLatch();
    testIdle();
    testRearm();
    testPulseShape();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule